// File: doc/BRIEF.md
# Audio Serial Master Transmitter

This block is the clock master of a one-wire stereo serial audio output. It divides the system clock into a bit clock and derives a frame clock from it. It takes a left and a right sample through a one-entry ready/valid holding register, and shifts both out MSB first on a single data line. Five framings are available: left-aligned, right-aligned, I2S and two pulse-synced packed modes. The packed modes differ only in whether the data starts in the sync slot or in the slot after it.

The configuration inputs are expected to stay constant while the block is out of reset. Changing the format, word length, divider or frame length is done with reset asserted. When the frame starts and no new sample pair is waiting, the block repeats the previous pair and raises a sticky underrun flag. The frame-start pulse lets the surrounding logic pace its sample production.

Top module: `audio_ser_tx`

## Requirements
- R1: `bclk` starts high after reset when `cfg_bclk_inv`=0 and toggles every `cfg_div`+1 clock cycles. When `cfg_bclk_inv`=1 the pin carries the inverse of that waveform.
- R2: `sdata` and `lrclk` change only on the clock edge that lowers the internal bit clock. On the pin this is the falling `bclk` edge with inversion off and the rising edge with inversion on.
- R3: A frame lasts FL bit periods, where FL = max(`cfg_frame_len` with bit 0 cleared, 2 × word length). `frame_start` is high for exactly one clock cycle, beginning at the launch of the first bit period of each frame.
- R4: `cfg_wlen` codes 0, 1, 2 and 3 select 16, 20, 24 and 32 bits. Samples are LSB-aligned in `smp_left`/`smp_right` and sent MSB first. Bit periods that carry no sample bit drive 0.
- R5: Left-aligned (`cfg_fmt`=0): `lrclk` is high for the first FL/2 bit periods (left) and low for the rest. Each word's MSB is in the first bit period of its half.
- R6: I2S (`cfg_fmt`=2): `lrclk` is low for the first FL/2 bit periods (left) and high for the rest. Each word's MSB is one bit period after the `lrclk` edge.
- R7: Right-aligned (`cfg_fmt`=1): `lrclk` is as in R5. Each word's LSB is in the last bit period of its half.
- R8: Packed early (`cfg_fmt`=3): `lrclk` is high only in bit period 0. The left MSB is in bit period 0 and the right word immediately follows the left LSB.
- R9: Packed late (`cfg_fmt`=4): the layout is as in R8, with both words one bit period later.
- R10: Right-aligned with 32-bit words is rejected: `cfg_err` is high and `sdata` stays 0.
- R11: `smp_ready` is high while the holding register is empty. A pair is accepted on an edge with `smp_valid` and `smp_ready` both high. It moves to the output words at the launch of the bit period where the left MSB belongs, which frees the holding register.
- R12: If the holding register is empty at that launch, the previous pair is sent again and `underrun` is set. `underrun` stays set until `urun_clr` is sampled high on an edge with no new underrun; a new underrun takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 3 | Framing select (0 left-aligned, 1 right-aligned, 2 I2S, 3 packed early, 4 packed late) |
| cfg_wlen | input | 2 | Word length code |
| cfg_bclk_inv | input | 1 | Bit clock inversion |
| cfg_div | input | DIV_W | Bit clock half period minus one, in clock cycles |
| cfg_frame_len | input | FRAME_W | Requested bit periods per frame |
| smp_valid | input | 1 | Sample pair valid |
| smp_ready | output | 1 | Holding register empty |
| smp_left | input | SAMPLE_W | Left sample, LSB-aligned |
| smp_right | input | SAMPLE_W | Right sample, LSB-aligned |
| urun_clr | input | 1 | Clears the underrun flag |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock or sync pulse |
| sdata | output | 1 | Serial data |
| frame_start | output | 1 | One-cycle pulse at each frame start |
| underrun | output | 1 | Sticky underrun flag |
| cfg_err | output | 1 | Unsupported format and length combination |

## Verification
`sdata`, `lrclk` and `frame_start` are registered on the launch edge, so their new values are due one edge after the bench's model decides that edge is a launch. `smp_ready` falls one edge after an accepting edge and rises one edge after the loading launch. `underrun` follows that same loading launch by one edge. The bench advances its behavioural model by one edge at every falling clock, using the inputs it has just driven. It then compares all outputs at the next falling clock, after exactly one register stage has acted.

// File: rtl/atx_pkg.sv
`timescale 1ns/1ps
package atx_pkg;
    typedef enum logic [2:0] {
        FMT_LEFT  = 3'd0,
        FMT_RIGHT = 3'd1,
        FMT_I2S   = 3'd2,
        FMT_PK_E  = 3'd3,
        FMT_PK_L  = 3'd4
    } fmt_e;

    function automatic logic [5:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    wlen_bits = 6'd16;
            2'd1:    wlen_bits = 6'd20;
            2'd2:    wlen_bits = 6'd24;
            default: wlen_bits = 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/atx_clkgen.sv
`timescale 1ns/1ps
module atx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             ph,
    output logic             launch
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             ph;
    } clk_s;

    clk_s st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.div == cfg_div) begin
            st_d.div = '0;
            st_d.ph  = ~st_q.ph;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div <= '0;
            st_q.ph  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph     = st_q.ph;
    assign launch = st_q.ph && (st_q.div == cfg_div);

    AST_BCLK_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.div != cfg_div) |=> $stable(st_q.ph)); // R1
endmodule

// File: rtl/atx_slotctr.sv
`timescale 1ns/1ps
module atx_slotctr #(
    parameter int FRAME_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [FRAME_W-1:0] wl,
    input  logic [FRAME_W-1:0] frame_len,
    output logic [FRAME_W-1:0] fl,
    output logic [FRAME_W-1:0] nb
);
    typedef struct packed {
        logic [FRAME_W-1:0] bitn;
    } slot_s;

    slot_s st_q, st_d;
    logic [FRAME_W-1:0] fl_req, fl_min;

    always_comb begin
        fl_req = frame_len & ~FRAME_W'(1);
        fl_min = wl << 1;
        fl     = (fl_req < fl_min) ? fl_min : fl_req;
        nb     = (st_q.bitn >= fl - 1'b1) ? '0 : st_q.bitn + 1'b1;
        st_d   = st_q;
        if (launch) st_d.bitn = nb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bitn <= '1;
        else        st_q <= st_d;
    end

    AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (st_q.bitn < fl)); // R3
endmodule

// File: rtl/atx_serializer.sv
`timescale 1ns/1ps
module atx_serializer
    import atx_pkg::*;
#(
    parameter int FRAME_W  = 9,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  fmt_e                fmt,
    input  logic [FRAME_W-1:0]  wl,
    input  logic [FRAME_W-1:0]  fl,
    input  logic [FRAME_W-1:0]  nb,
    input  logic                err,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                urun_clr,
    output logic                smp_ready,
    output logic                sdata,
    output logic                lrclk,
    output logic                frame_start,
    output logic                underrun
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic [SAMPLE_W-1:0] word_l;
        logic [SAMPLE_W-1:0] word_r;
        logic                hold_v;
        logic                sdata;
        logic                lrclk;
        logic                fstart;
        logic                urun;
    } ser_s;

    ser_s st_q, st_d;

    logic [FRAME_W-1:0]  half, p, pos, k, lead, idx;
    logic [SAMPLE_W-1:0] word;
    logic                off, right, vld, load, set_u, bit_v;

    always_comb begin
        st_d  = st_q;
        half  = fl >> 1;
        off   = (fmt == FMT_I2S) || (fmt == FMT_PK_L);
        p     = (nb >= FRAME_W'(off)) ? nb - FRAME_W'(off) : fl - 1'b1;
        load  = launch && (p == '0);
        set_u = load && !st_q.hold_v;

        if (load && st_q.hold_v) begin
            st_d.word_l = st_q.hold_l;
            st_d.word_r = st_q.hold_r;
            st_d.hold_v = 1'b0;
        end
        if (set_u)         st_d.urun = 1'b1;
        else if (urun_clr) st_d.urun = 1'b0;

        if (smp_valid && !st_q.hold_v) begin
            st_d.hold_l = smp_left;
            st_d.hold_r = smp_right;
            st_d.hold_v = 1'b1;
        end

        lead = half - wl;
        if (fmt == FMT_PK_E || fmt == FMT_PK_L) begin
            right = (p >= wl);
            k     = right ? p - wl : p;
            vld   = (p < (wl << 1));
        end else begin
            right = (p >= half);
            pos   = right ? p - half : p;
            if (fmt == FMT_RIGHT) begin
                vld = (pos >= lead);
                k   = pos - lead;
            end else begin
                vld = (pos < wl);
                k   = pos;
            end
        end
        if (fmt == FMT_PK_E || fmt == FMT_PK_L) pos = '0;

        word  = right ? st_d.word_r : st_d.word_l;
        idx   = wl - 1'b1 - k;
        bit_v = |(word & (SAMPLE_W'(1) << idx));

        if (launch) begin
            st_d.sdata = vld && !err && bit_v;
            case (fmt)
                FMT_I2S:          st_d.lrclk = (nb >= half);
                FMT_PK_E, FMT_PK_L: st_d.lrclk = (nb == '0);
                default:          st_d.lrclk = (nb < half);
            endcase
        end
        st_d.fstart = launch && (nb == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_ready   = !st_q.hold_v;
    assign sdata       = st_q.sdata;
    assign lrclk       = st_q.lrclk;
    assign frame_start = st_q.fstart;
    assign underrun    = st_q.urun;

    AST_DATA_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable({st_q.sdata, st_q.lrclk})); // R2
    AST_SILENT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !st_q.sdata); // R10
    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.urun && !urun_clr) |=> st_q.urun); // R12
    AST_HOLD_UNTIL_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold_v && !launch) |=> st_q.hold_v); // R11
    AST_FSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fstart |=> !st_q.fstart); // R3
endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
module audio_ser_tx
    import atx_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int FRAME_W  = 9,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_fmt,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_bclk_inv,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [FRAME_W-1:0]  cfg_frame_len,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                urun_clr,
    output logic                bclk,
    output logic                lrclk,
    output logic                sdata,
    output logic                frame_start,
    output logic                underrun,
    output logic                cfg_err
);
    fmt_e               fmt;
    logic [FRAME_W-1:0] wl, fl, nb;
    logic               ph, launch;

    assign fmt     = fmt_e'(cfg_fmt);
    assign wl      = FRAME_W'(wlen_bits(cfg_wlen));
    assign cfg_err = (fmt == FMT_RIGHT) && (cfg_wlen == 2'd3);
    assign bclk    = ph ^ cfg_bclk_inv;

    atx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .ph(ph), .launch(launch)
    );

    atx_slotctr #(.FRAME_W(FRAME_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .launch(launch), .wl(wl),
        .frame_len(cfg_frame_len), .fl(fl), .nb(nb)
    );

    atx_serializer #(.FRAME_W(FRAME_W), .SAMPLE_W(SAMPLE_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .launch(launch), .fmt(fmt), .wl(wl),
        .fl(fl), .nb(nb), .err(cfg_err), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .urun_clr(urun_clr),
        .smp_ready(smp_ready), .sdata(sdata), .lrclk(lrclk),
        .frame_start(frame_start), .underrun(underrun)
    );
endmodule

// File: tb/tb_audio_ser_tx.sv
`timescale 1ns/1ps
module tb_audio_ser_tx;
    localparam int DIV_W = 8, FRAME_W = 9, SAMPLE_W = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] cfg_fmt = '0;
    logic [1:0] cfg_wlen = '0;
    logic cfg_bclk_inv = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [FRAME_W-1:0] cfg_frame_len = '0;
    logic smp_valid = 1'b0, urun_clr = 1'b0;
    logic [SAMPLE_W-1:0] smp_left = '0, smp_right = '0;
    logic smp_ready, bclk, lrclk, sdata, frame_start, underrun, cfg_err;

    audio_ser_tx #(.DIV_W(DIV_W), .FRAME_W(FRAME_W), .SAMPLE_W(SAMPLE_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_div(cfg_div), .cfg_frame_len(cfg_frame_len),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left),
        .smp_right(smp_right), .urun_clr(urun_clr), .bclk(bclk), .lrclk(lrclk),
        .sdata(sdata), .frame_start(frame_start), .underrun(underrun), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit run = 0, feed_en = 0, acc_flag = 0;

    // model configuration
    int m_fmt, m_wl, m_hp, m_fl, m_off, m_inv;
    bit m_err;
    string ftag;
    // model state
    int c;
    logic [31:0] cur_l, cur_r, q_l, q_r;
    bit q_v, e_urun, e_sd, e_lr, e_fs;
    bit frame_bits [0:511];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", req, what, act, exp, c);
        end
    endtask

    // lay out one frame's serial stream, indexed by data position
    task automatic build_frame();
        int ls, rs, h;
        h = m_fl / 2;
        for (int i = 0; i < 512; i++) frame_bits[i] = 1'b0;
        case (m_fmt)
            1:       begin ls = h - m_wl; rs = m_fl - m_wl; end
            3, 4:    begin ls = 0; rs = m_wl; end
            default: begin ls = 0; rs = h; end
        endcase
        for (int i = 0; i < m_wl; i++) begin
            frame_bits[ls + i] = cur_l[m_wl - 1 - i];
            frame_bits[rs + i] = cur_r[m_wl - 1 - i];
        end
    endtask

    function automatic bit exp_lr(input int b);
        case (m_fmt)
            2:       return b >= m_fl / 2;
            3, 4:    return b == 0;
            default: return b < m_fl / 2;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && run) begin
            int ph, c1, s, b, p;
            bit rdy, set_u, launch;
            ph = 1 ^ ((c / m_hp) & 1);
            chk(bclk == (ph ^ m_inv), "R1", "bclk", bclk, ph ^ m_inv);
            chk(lrclk == e_lr, {"R2 ", ftag}, "lrclk", lrclk, e_lr);
            chk(sdata == e_sd, {"R2 R4 ", ftag}, "sdata", sdata, e_sd);
            chk(frame_start == e_fs, "R3", "frame_start", frame_start, e_fs);
            chk(underrun == e_urun, "R12", "underrun", underrun, e_urun);
            chk(smp_ready == !q_v, "R11", "smp_ready", smp_ready, !q_v);
            chk(cfg_err == m_err, "R10", "cfg_err", cfg_err, m_err);
            // advance the model across the coming edge
            c1 = c + 1;
            rdy = !q_v;
            set_u = 0;
            launch = (c1 % m_hp == 0) && (((c1 / m_hp) % 2) == 1);
            e_fs = 0;
            if (launch) begin
                s = (c1 / m_hp - 1) / 2;
                b = s % m_fl;
                p = (b - m_off + m_fl) % m_fl;
                if (p == 0) begin
                    if (q_v) begin cur_l = q_l; cur_r = q_r; q_v = 0; end
                    else set_u = 1;
                    build_frame();
                end
                e_sd = m_err ? 1'b0 : frame_bits[p];
                e_lr = exp_lr(b);
                e_fs = (b == 0);
            end
            if (set_u) e_urun = 1;
            else if (urun_clr) e_urun = 0;
            if (smp_valid && rdy) begin
                q_l = smp_left; q_r = smp_right; q_v = 1; acc_flag = 1;
            end
            c = c1;
        end
    end

    // sample source
    initial forever begin
        @(posedge clk); #2;
        if (acc_flag) begin
            smp_left = $urandom; smp_right = $urandom; acc_flag = 0;
        end
        smp_valid = feed_en;
    end

    task automatic start_case(input int fmt, input int wlc, input int inv,
                              input int div, input int flen, input string tag);
        int req;
        @(posedge clk); #2;
        run = 0; rst_n = 0; feed_en = 0; acc_flag = 0; urun_clr = 0;
        cfg_fmt = 3'(fmt); cfg_wlen = 2'(wlc); cfg_bclk_inv = inv[0];
        cfg_div = DIV_W'(div); cfg_frame_len = FRAME_W'(flen);
        smp_left = $urandom; smp_right = $urandom;
        m_fmt = fmt; m_inv = inv;
        m_wl = (wlc == 0) ? 16 : (wlc == 1) ? 20 : (wlc == 2) ? 24 : 32;
        m_hp = div + 1;
        req = flen & ~1;
        m_fl = (req < 2 * m_wl) ? 2 * m_wl : req;
        m_off = (fmt == 2 || fmt == 4) ? 1 : 0;
        m_err = (fmt == 1 && wlc == 3);
        ftag = tag;
        c = 0; cur_l = 0; cur_r = 0; q_v = 0;
        e_urun = 0; e_sd = 0; e_lr = 0; e_fs = 0;
        for (int i = 0; i < 512; i++) frame_bits[i] = 1'b0;
        feed_en = 1;
        repeat (3) @(posedge clk);
        #2; rst_n = 1; run = 1;
    endtask

    initial begin
        // R5 left-aligned, 16 bits
        start_case(0, 0, 0, 1, 32, "R5");
        repeat (1500) @(posedge clk);
        // R12: starve the source, then clear the flag
        feed_en = 0;
        repeat (600) @(posedge clk);
        #2; urun_clr = 1; @(posedge clk); #2; urun_clr = 0;
        repeat (50) @(posedge clk);
        feed_en = 1;
        repeat (800) @(posedge clk);
        #2; urun_clr = 1; @(posedge clk); #2; urun_clr = 0;
        repeat (600) @(posedge clk);
        // R6 I2S, 24 bits, fastest divider
        start_case(2, 2, 0, 0, 64, "R6");
        repeat (2000) @(posedge clk);
        // R7 right-aligned, 20 bits, odd frame length 49 -> 48
        start_case(1, 1, 0, 2, 49, "R7");
        repeat (3000) @(posedge clk);
        // R8 packed early, 16 bits, frame length 20 clamped to 32
        start_case(3, 0, 0, 1, 20, "R8 R3");
        repeat (2000) @(posedge clk);
        // R9 packed late, 32 bits, inverted bit clock
        start_case(4, 3, 1, 3, 70, "R9 R1");
        repeat (3000) @(posedge clk);
        // R10 right-aligned with 32 bits is rejected
        start_case(1, 3, 0, 1, 80, "R10 R7");
        repeat (1500) @(posedge clk);
        // R5 left-aligned, 24 bits, inverted bit clock
        start_case(0, 2, 1, 2, 60, "R5 R1");
        repeat (2000) @(posedge clk);
        run = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule